// File: doc/BRIEF.md
# Glitch-Hardened Two-of-Seven Link Receiver

This block terminates one direction of a delay-insensitive chip-to-chip link. The far end sends each symbol by toggling exactly two of seven wires (two-phase signalling), and waits for a toggle on the acknowledge wire before it sends the next one. The receiver oversamples the wires with the core clock and synchronises them. It compares them against a stored copy of the last settled wire levels. It resolves every pattern it sees into one of three results: a 4-bit flit, an end-of-packet marker, or a discard. Flits leave through a valid/ready port. End-of-packet leaves on a separate one-cycle strobe. The link acknowledge toggles once per resolved symbol.

The block is built so that corrupted traffic cannot hang it. A pattern counts only when it has been stable for two consecutive samples, so short wire pulses are filtered out. A lone transition that is never joined by a second one is paired, after a timeout, with a fixed default wire. Patterns with three or more transitions are dropped. Codes that are legal two-hot patterns but carry no meaning are mapped onto data values. On leaving reset the receiver sends one acknowledge toggle unprompted, so that a transmitter already waiting for one is released. A saturating counter reports every coerced or dropped symbol.

Reset must be held for at least three clock cycles, so that the stored wire levels are captured from the synchroniser output.

Top module: `sym_link_rx`

## Requirements
- R1: Wire indices run 0..6. A pair of wires (i, j) with i < j gets the code k = position of (i, j) in the ascending list (0,1), (0,2), ..., (0,6), (1,2), ..., (5,6). When exactly two wires have toggled relative to the stored levels and stay so for two samples, codes k = 0..15 give a flit with out_data = k, and err_count does not change.
- R2: Code k = 16 (wires 3 and 5) gives exactly one single-cycle eop_strobe pulse and no flit. It toggles link_ack once and leaves err_count unchanged.
- R3: Codes k = 17..20 (pairs (3,6), (4,5), (4,6), (5,6)) give a flit with out_data = k − 16, and err_count increases by 1.
- R4: A settled pattern with three or more toggled wires gives no flit and no eop_strobe. It toggles link_ack once and increases err_count by 1.
- R5: A single toggled wire w that stays alone for TIMEOUT_CYC stable samples is paired with wire DEF_WIRE (default 6). If w equals DEF_WIRE, it is paired with wire 0 instead. The pair is then decoded as in R1–R3 and err_count increases by 1. With the defaults, wire 2 alone gives data 14 and wire 6 alone gives data 5.
- R6: After every resolution the stored levels take the current wire levels. A following symbol is therefore decoded correctly from the new levels, including after a discard.
- R7: A single-wire pulse that returns to its old level before the timeout gives no flit, no eop_strobe and no link_ack toggle, and leaves err_count unchanged.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_data stays unchanged and link_ack does not toggle. A flit handshake toggles link_ack exactly once and drops out_valid.
- R9: During reset, out_valid, eop_strobe, err_count and link_ack are 0. After reset is released, link_ack toggles exactly once with no symbol on the wires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| link_wires | input | 7 | Two-phase symbol wires from the link |
| link_ack | output | 1 | Two-phase acknowledge back to the link |
| out_valid | output | 1 | Flit available |
| out_ready | input | 1 | Downstream accepts the flit |
| out_data | output | 4 | Flit value |
| eop_strobe | output | 1 | One-cycle end-of-packet marker |
| err_count | output | CNT_W | Saturating count of coerced and dropped symbols |

## Verification
All sixteen data pairs are sent and the flit value is compared with the code position. This separates a correct pairing order from a shifted or mirrored one. The end-of-packet pair, the four unused pairs and a three-wire pattern each exercise a different resolution path, and each has its own expected effect on the strobe, the acknowledge and the error count. Two lone wires, one of them the default wire itself, exercise the timeout pairing. A short pulse on one wire, followed by a normal pair, shows that glitches are filtered and that the stored levels recover. A held flit under back-pressure shows that the data and the acknowledge wait for the handshake.

// File: rtl/sym_link_rx_pkg.sv
package sym_link_rx_pkg;

    localparam int NW         = 7;
    localparam int IDX_W      = $clog2(NW);
    localparam int FLIT_W     = 4;
    localparam int DATA_CODES = 16;
    localparam int EOP_CODE   = 16;

    typedef logic [NW-1:0]     wires_t;
    typedef logic [IDX_W-1:0]  wire_idx_t;
    typedef logic [FLIT_W-1:0] flit_t;

    typedef enum logic [1:0] {
        SYM_DATA = 2'd0,
        SYM_EOP  = 2'd1,
        SYM_DROP = 2'd2
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e kind;
        flit_t     data;
        logic      fault;
    } sym_res_t;

    function automatic int popcnt(wires_t v);
        int n = 0;
        for (int i = 0; i < NW; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // lowest set bit wins
    function automatic wire_idx_t low_idx(wires_t v);
        wire_idx_t r = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (v[i]) r = wire_idx_t'(i);
        end
        return r;
    endfunction

    // ascending lexicographic position of pair (a,b), a<b
    function automatic int pair_index(wire_idx_t a, wire_idx_t b);
        int k = 0;
        for (int x = 0; x < NW; x++) begin
            if (x < int'(a)) k += NW - 1 - x;
        end
        return k + int'(b) - int'(a) - 1;
    endfunction

    function automatic sym_res_t decode_pair(wire_idx_t a, wire_idx_t b);
        sym_res_t r;
        int k;
        k = pair_index(a, b);
        r.kind  = SYM_DATA;
        r.data  = '0;
        r.fault = 1'b0;
        if (k < DATA_CODES) begin
            r.data = flit_t'(k);
        end else if (k == EOP_CODE) begin
            r.kind = SYM_EOP;
        end else begin
            r.data  = flit_t'(k - DATA_CODES);
            r.fault = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sym_link_rx_sync.sv
module sym_link_rx_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/sym_link_rx_resolve.sv
module sym_link_rx_resolve
    import sym_link_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int DEF_WIRE    = 6,
    localparam int TMO_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  wires_t   wires_s,
    input  logic     accept_en,
    output logic     res_valid,
    output sym_res_t res
);
    localparam wire_idx_t DEF_IDX = wire_idx_t'(DEF_WIRE);
    localparam wire_idx_t ALT_IDX = wire_idx_t'((DEF_WIRE == 0) ? 1 : 0);

    wires_t     ref_q;
    wires_t     diff;
    wires_t     diff_q;
    wires_t     masked;
    logic [TMO_W-1:0] tmo_q;
    int         n_tog;
    logic       stable;
    logic       tmo_hit;
    wire_idx_t  lo;
    wire_idx_t  hi;
    wire_idx_t  partner;
    wire_idx_t  pa;
    wire_idx_t  pb;

    always_comb begin
        diff    = wires_s ^ ref_q;
        n_tog   = popcnt(diff);
        stable  = (diff == diff_q) && (diff != '0);
        lo      = low_idx(diff);
        masked  = diff;
        masked[lo] = 1'b0;
        hi      = low_idx(masked);
        partner = (lo == DEF_IDX) ? ALT_IDX : DEF_IDX;
        tmo_hit = (tmo_q == TMO_W'(TIMEOUT_CYC - 1));

        pa = (lo < partner) ? lo : partner;
        pb = (lo < partner) ? partner : lo;

        res_valid = accept_en && stable &&
                    ((n_tog >= 2) || ((n_tog == 1) && tmo_hit));

        if (n_tog > 2) begin
            res.kind  = SYM_DROP;
            res.data  = '0;
            res.fault = 1'b1;
        end else if (n_tog == 2) begin
            res = decode_pair(lo, hi);
        end else begin
            res = decode_pair(pa, pb);
            res.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= wires_s;
            diff_q <= '0;
            tmo_q  <= '0;
        end else begin
            diff_q <= diff;
            if (res_valid) begin
                ref_q <= wires_s;
            end
            if (res_valid || !(accept_en && stable && (n_tog == 1))) begin
                tmo_q <= '0;
            end else begin
                tmo_q <= tmo_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sym_link_rx_ctrl.sv
module sym_link_rx_ctrl
    import sym_link_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  sym_res_t         res,
    input  logic             out_ready,
    output logic             accept_en,
    output logic             out_valid,
    output flit_t            out_data,
    output logic             eop_strobe,
    output logic             link_ack,
    output logic [CNT_W-1:0] err_count
);
    typedef enum logic {ST_IDLE, ST_HOLD} ctrl_state_e;

    ctrl_state_e state_q;
    logic        boot_q;
    logic        ack_q;
    logic        eop_q;
    flit_t       data_q;
    logic [CNT_W-1:0] err_q;
    logic        take;
    logic        toggle;

    always_comb begin
        accept_en = (state_q == ST_IDLE) && !boot_q;
        take      = accept_en && res_valid;
        toggle    = boot_q
                  || (take && (res.kind != SYM_DATA))
                  || ((state_q == ST_HOLD) && out_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            boot_q  <= 1'b1;
            ack_q   <= 1'b0;
            eop_q   <= 1'b0;
            data_q  <= '0;
            err_q   <= '0;
        end else begin
            boot_q <= 1'b0;
            eop_q  <= take && (res.kind == SYM_EOP);
            if (toggle) begin
                ack_q <= ~ack_q;
            end
            if (take && res.fault && (err_q != '1)) begin
                err_q <= err_q + 1'b1;
            end
            case (state_q)
                ST_IDLE: if (take && (res.kind == SYM_DATA)) begin
                    data_q  <= res.data;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: if (out_ready) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_valid  = (state_q == ST_HOLD);
    assign out_data   = data_q;
    assign eop_strobe = eop_q;
    assign link_ack   = ack_q;
    assign err_count  = err_q;
endmodule

// File: rtl/sym_link_rx.sv
module sym_link_rx
    import sym_link_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int DEF_WIRE    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       link_wires,
    output logic             link_ack,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_data,
    output logic             eop_strobe,
    output logic [CNT_W-1:0] err_count
);
    wires_t   wires_s;
    logic     accept_en;
    logic     res_valid;
    sym_res_t res;

    sym_link_rx_sync #(.W(NW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (link_wires),
        .dout (wires_s)
    );

    sym_link_rx_resolve #(.TIMEOUT_CYC(TIMEOUT_CYC), .DEF_WIRE(DEF_WIRE)) u_resolve (
        .clk       (clk),
        .rst       (rst),
        .wires_s   (wires_s),
        .accept_en (accept_en),
        .res_valid (res_valid),
        .res       (res)
    );

    sym_link_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .res_valid  (res_valid),
        .res        (res),
        .out_ready  (out_ready),
        .accept_en  (accept_en),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .eop_strobe (eop_strobe),
        .link_ack   (link_ack),
        .err_count  (err_count)
    );
endmodule

// File: rtl/sym_link_rx_chk.sv
module sym_link_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             link_ack,
    input logic             out_valid,
    input logic             out_ready,
    input logic [3:0]       out_data,
    input logic             eop_strobe,
    input logic [CNT_W-1:0] err_count
);
    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    ack_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(link_ack));

    // R2
    eop_ack_chk: assert property (@(posedge clk) disable iff (rst)
        eop_strobe |-> (link_ack != $past(link_ack)));

    // R2
    eop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        eop_strobe |-> !out_valid);

    // R3
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (err_count != {CNT_W{1'b1}}) |=>
            ((err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)));

    // R8
    hs_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && (link_ack != $past(link_ack))));
endmodule

bind sym_link_rx sym_link_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_ack   (link_ack),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .eop_strobe (eop_strobe),
    .err_count  (err_count)
);

// File: tb/sym_link_rx_bench.sv
module sym_link_rx_bench;
    localparam int TMO   = 16;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [6:0]       link_wires;
    logic             link_ack;
    logic             out_valid;
    logic             out_ready;
    logic [3:0]       out_data;
    logic             eop_strobe;
    logic [CNT_W-1:0] err_count;

    int checks = 0;
    int fails  = 0;
    int ack_tog, eop_seen;
    logic valid_seen;
    logic prev_ack;
    logic done = 1'b0;

    always #2 clk = ~clk;

    sym_link_rx #(.TIMEOUT_CYC(TMO), .CNT_W(CNT_W)) u_sym_link_rx (
        .clk(clk), .rst(rst), .link_wires(link_wires), .link_ack(link_ack),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .eop_strobe(eop_strobe), .err_count(err_count)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (link_ack !== prev_ack) ack_tog++;
        prev_ack = link_ack;
        if (eop_strobe) eop_seen++;
        if (out_valid) valid_seen = 1'b1;
    endtask

    task automatic clear_obs();
        ack_tog = 0; eop_seen = 0; valid_seen = 1'b0;
    endtask

    function automatic int code_of(int i, int j);
        int k = 0;
        for (int a = 0; a < 7; a++)
            for (int b = a + 1; b < 7; b++) begin
                if (a == i && b == j) return k;
                k++;
            end
        return -1;
    endfunction

    // send mask, expect a flit
    task automatic t_flit(input logic [6:0] mask, input int exp_data, input int derr, input string tag);
        int e0 = int'(err_count);
        clear_obs();
        link_wires = link_wires ^ mask;
        for (int c = 0; c < TMO + 40 && !out_valid; c++) step();
        check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
        check(int'(out_data) == exp_data, {tag, " data"}, int'(out_data), exp_data);
        check(ack_tog == 0 && eop_seen == 0, {tag, " no early ack"}, ack_tog, 0);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        check(ack_tog == 1 && !out_valid, {tag, " ack after handshake"}, ack_tog, 1);
        check(int'(err_count) == e0 + derr, {tag, " err_count"}, int'(err_count), e0 + derr);
    endtask

    task automatic t_reset();
        rst = 1'b1; link_wires = '0; out_ready = 1'b0;
        prev_ack = 1'b0;
        repeat (6) @(negedge clk);
        check(!out_valid && !eop_strobe && err_count == 0 && !link_ack,
              "R9 reset outputs", int'(out_valid) + int'(link_ack), 0);
        rst = 1'b0;
        clear_obs();
        prev_ack = link_ack;
        repeat (12) step();
        check(ack_tog == 1, "R9 boot ack toggle count", ack_tog, 1);
        check(link_ack == 1'b1, "R9 boot ack level", int'(link_ack), 1);
        check(!valid_seen && eop_seen == 0, "R9 quiet after reset", int'(valid_seen), 0);
    endtask

    task automatic t_all_data();
        int k = 0;
        for (int a = 0; a < 7; a++)
            for (int b = a + 1; b < 7; b++) begin
                if (code_of(a, b) < 16)
                    t_flit(7'(1 << a) | 7'(1 << b), code_of(a, b), 0, $sformatf("R1 pair %0d,%0d", a, b));
                k++;
            end
    endtask

    task automatic t_backpressure();
        logic stable_ok = 1'b1;
        clear_obs();
        link_wires = link_wires ^ 7'b0000101;
        for (int c = 0; c < 40 && !out_valid; c++) step();
        for (int c = 0; c < 20; c++) begin
            step();
            if (!out_valid || out_data != 4'd1) stable_ok = 1'b0;
        end
        check(stable_ok, "R8 held flit stable", int'(out_data), 1);
        check(ack_tog == 0, "R8 ack waits for handshake", ack_tog, 0);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        check(ack_tog == 1, "R8 single ack on handshake", ack_tog, 1);
    endtask

    task automatic t_eop();
        int e0 = int'(err_count);
        clear_obs();
        link_wires = link_wires ^ 7'b0101000;
        repeat (40) step();
        check(eop_seen == 1, "R2 eop pulse count", eop_seen, 1);
        check(!valid_seen, "R2 no flit for eop", int'(valid_seen), 0);
        check(ack_tog == 1, "R2 eop ack", ack_tog, 1);
        check(int'(err_count) == e0, "R2 err unchanged", int'(err_count), e0);
    endtask

    task automatic t_unused();
        t_flit(7'b1001000, 1, 1, "R3 pair 3,6");
        t_flit(7'b0110000, 2, 1, "R3 pair 4,5");
        t_flit(7'b1010000, 3, 1, "R3 pair 4,6");
        t_flit(7'b1100000, 4, 1, "R3 pair 5,6");
    endtask

    task automatic t_triple();
        int e0 = int'(err_count);
        clear_obs();
        link_wires = link_wires ^ 7'b0000111;
        repeat (40) step();
        check(!valid_seen && eop_seen == 0, "R4 triple dropped", int'(valid_seen), 0);
        check(ack_tog == 1, "R4 triple acked", ack_tog, 1);
        check(int'(err_count) == e0 + 1, "R4 err count", int'(err_count), e0 + 1);
        t_flit(7'b0000011, 0, 0, "R6 pair after drop");
    endtask

    task automatic t_single();
        t_flit(7'b0000100, 14, 1, "R5 lone wire 2");
        t_flit(7'b1000000, 5, 1, "R5 lone default wire");
    endtask

    task automatic t_glitch();
        int e0 = int'(err_count);
        clear_obs();
        link_wires = link_wires ^ 7'b0000010;
        repeat (4) step();
        link_wires = link_wires ^ 7'b0000010;
        repeat (40) step();
        check(!valid_seen && eop_seen == 0 && ack_tog == 0, "R7 pulse ignored", ack_tog, 0);
        check(int'(err_count) == e0, "R7 err unchanged", int'(err_count), e0);
        t_flit(7'b0000110, 6, 0, "R6 pair after pulse");
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_all_data();
        t_backpressure();
        t_eop();
        t_unused();
        t_triple();
        t_single();
        t_glitch();
        done = 1'b1;
        report();
        $finish;
    end
endmodule